// File: doc/BRIEF.md
# Maskable CAN Identifier Acceptance Filter

This block decides whether the identifier of a received CAN frame is kept. The frame receiver presents the four identifier bytes of a frame as one 32-bit word, together with a single-cycle strobe. The word is compared at the same time against a set of 32-bit filter banks. Each bank has its own acceptance pattern and its own mask. A set mask bit makes the matching identifier bit don't care. The two default banks cover the whole extended identifier and also its substitute-remote, extension and remote-request bits.

When a frame passes one or more banks, the block raises a receive-full flag. It also loads a hit code that names the lowest-numbered bank that matched. If no bank matches, the frame is silently dropped. A passing frame that arrives while the full flag is still set is refused, and an overrun flag is raised instead. The host clears the full flag and the overrun flag with write-one strobes. The hit code stays valid until the next accepted frame. The patterns and masks arrive on plain input ports, so any host register file can drive them.

Top module: `can_id_filter`

## Requirements
- R1: After reset, `rx_full` is 0, `overrun` is 0 and `hit_code` is 0.
- R2: A bank passes a frame when every bit of `frame_id` either equals the bank's pattern bit or has its mask bit set to 1. One cycle after the strobe, a passing frame sets `rx_full`.
- R3: Bank k uses bits [32k+31:32k] of both `acc_pattern` and `acc_mask`. After an accepted frame, `hit_code` equals the number of the bank that matched.
- R4: When several banks match, `hit_code` takes the lowest bank number.
- R5: A frame that matches no bank leaves `rx_full`, `hit_code` and `overrun` unchanged.
- R6: A matching frame that arrives while `rx_full` is 1 (and not cleared in that cycle) is dropped. `hit_code` keeps its value, and `overrun` becomes 1 on the next cycle.
- R7: A pulse on `clr_full` clears `rx_full` on the next cycle, and `hit_code` keeps its value.
- R8: A pulse on `clr_ovr` clears `overrun` on the next cycle.
- R9: The extended layout of `frame_id` is fixed as follows:
  - bits [31:21] = ID28..ID18
  - bit 20 = SRR
  - bit 19 = IDE
  - bits [18:1] = ID17..ID0
  - bit 0 = RTR

  A mismatch on SRR, IDE or RTR that is not masked rejects the frame.
- R10: A standard frame is placed as follows, and it is filtered with the lower 19 bits masked:
  - bits [31:21] = ID10..ID0
  - bit 20 = RTR
  - bit 19 = IDE
- R11: If `clr_full` and a matching strobe arrive in the same cycle, the clear takes effect first and the frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe: `frame_id` holds a received identifier |
| frame_id | input | 32 | Packed identifier bytes, byte 0 in bits [31:24] |
| acc_pattern | input | 64 | Acceptance patterns, bank k in bits [32k+31:32k] |
| acc_mask | input | 64 | Masks, 1 = don't care, same bank layout |
| clr_full | input | 1 | Write-one strobe that clears `rx_full` |
| clr_ovr | input | 1 | Write-one strobe that clears `overrun` |
| rx_full | output | 1 | An accepted frame is waiting |
| overrun | output | 1 | A matching frame was refused because the buffer was full |
| hit_code | output | 3 | Number of the bank that accepted the last frame |

## Verification
The checker watches the following on every cycle:
- the ordering between the full flag and the strobes;
- that rejected frames leave the status still;
- that a frame refused for a full buffer sets `overrun` and does not touch `hit_code`;
- that bank 0 wins whenever it matches;
- that `hit_code` never names a bank that does not exist.

Some properties can only be shown by the bench's scenarios, because they depend on the chosen pattern and mask values:
- that the mask polarity is correct;
- that SRR, IDE and RTR sit in the right bit positions;
- that a standard identifier filters correctly;
- that a bank other than 0 is reported by number.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

  localparam int unsigned ID_BYTES = 4;
  localparam int unsigned ID_W     = 8 * ID_BYTES;

  typedef logic [ID_W-1:0] id_word_t;
  typedef logic [7:0]      id_byte_t;

  // One byte passes when each bit is equal or masked (mask 1 = ignore).
  function automatic logic byte_pass(input id_byte_t rx,
                                     input id_byte_t pat,
                                     input id_byte_t msk);
    id_byte_t diff;
    diff = (rx ^ pat) & ~msk;
    return (diff == '0);
  endfunction

  // Number of the lowest set bit of a match vector; 0 if none set.
  function automatic int unsigned lowest_set(input logic [31:0] vec,
                                             input int unsigned n);
    int unsigned idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (i < int'(n) && vec[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/filt_bank.sv
module filt_bank
  import can_filt_pkg::*;
#(
  parameter int unsigned BYTES = ID_BYTES
) (
  input  logic [8*BYTES-1:0] rx_id,
  input  logic [8*BYTES-1:0] pattern,
  input  logic [8*BYTES-1:0] mask,
  output logic               bank_hit
);

  logic [BYTES-1:0] byte_ok;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign byte_ok[b] = byte_pass(rx_id[8*b +: 8], pattern[8*b +: 8], mask[8*b +: 8]);
  end

  assign bank_hit = &byte_ok;

endmodule

// File: rtl/hit_prio.sv
module hit_prio
  import can_filt_pkg::*;
#(
  parameter int unsigned N      = 2,
  parameter int unsigned CODE_W = 3
) (
  input  logic [N-1:0]      match,
  output logic              any_hit,
  output logic [CODE_W-1:0] code
);

  logic [31:0] match_wide;

  always_comb begin
    match_wide = '0;
    match_wide[N-1:0] = match;
  end

  assign any_hit = |match;
  assign code    = CODE_W'(lowest_set(match_wide, N));

endmodule

// File: rtl/rx_status.sv
module rx_status #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_valid,
  input  logic              any_hit,
  input  logic [CODE_W-1:0] win_code,
  input  logic              clr_full,
  input  logic              clr_ovr,
  output logic              rx_full,
  output logic              overrun,
  output logic [CODE_W-1:0] hit_code,
  output logic              accept_ev,
  output logic              refuse_ev
);

  logic full_eff;

  // A clear in the same cycle frees the buffer before the frame is judged.
  assign full_eff  = rx_full & ~clr_full;
  assign accept_ev = frame_valid & any_hit & ~full_eff;
  assign refuse_ev = frame_valid & any_hit &  full_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full  <= 1'b0;
      overrun  <= 1'b0;
      hit_code <= '0;
    end else begin
      if (accept_ev) begin
        rx_full  <= 1'b1;
        hit_code <= win_code;
      end else if (clr_full) begin
        rx_full  <= 1'b0;
      end
      if (refuse_ev)    overrun <= 1'b1;
      else if (clr_ovr) overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_filt_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned HIT_W     = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_valid,
  input  logic [ID_W-1:0]           frame_id,
  input  logic [NUM_BANKS*ID_W-1:0] acc_pattern,
  input  logic [NUM_BANKS*ID_W-1:0] acc_mask,
  input  logic                      clr_full,
  input  logic                      clr_ovr,
  output logic                      rx_full,
  output logic                      overrun,
  output logic [HIT_W-1:0]          hit_code
);

  localparam int unsigned BANK_W = ID_W;

  logic [NUM_BANKS-1:0] match_vec;
  logic                 any_match;
  logic [HIT_W-1:0]     win_code;
  logic                 accept_ev;
  logic                 refuse_ev;

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    filt_bank #(.BYTES(ID_BYTES)) u_bank (
      .rx_id    (frame_id),
      .pattern  (acc_pattern[BANK_W*k +: BANK_W]),
      .mask     (acc_mask[BANK_W*k +: BANK_W]),
      .bank_hit (match_vec[k])
    );
  end

  hit_prio #(.N(NUM_BANKS), .CODE_W(HIT_W)) u_prio (
    .match   (match_vec),
    .any_hit (any_match),
    .code    (win_code)
  );

  rx_status #(.CODE_W(HIT_W)) u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .any_hit     (any_match),
    .win_code    (win_code),
    .clr_full    (clr_full),
    .clr_ovr     (clr_ovr),
    .rx_full     (rx_full),
    .overrun     (overrun),
    .hit_code    (hit_code),
    .accept_ev   (accept_ev),
    .refuse_ev   (refuse_ev)
  );

endmodule

// File: rtl/can_id_filter_chk.sv
module can_id_filter_chk #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned HIT_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_valid,
  input logic                 clr_full,
  input logic                 clr_ovr,
  input logic                 rx_full,
  input logic                 overrun,
  input logic [HIT_W-1:0]     hit_code,
  input logic [NUM_BANKS-1:0] match_vec,
  input logic                 any_match,
  input logic                 accept_ev,
  input logic                 refuse_ev
);

  // R2
  accept_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> rx_full);

  // R2
  full_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(frame_valid && any_match));

  // R3
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hit_code) < int'(NUM_BANKS));

  // R4
  bank0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && match_vec[0]) |=> (hit_code == '0));

  // R5
  reject_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !any_match && !clr_full && !clr_ovr) |=>
      ($stable(rx_full) && $stable(hit_code) && $stable(overrun)));

  // R6
  refuse_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && any_match && rx_full && !clr_full) |=>
      (overrun && rx_full && $stable(hit_code)));

  // R7
  clear_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_full && !accept_ev) |=> (!rx_full && $stable(hit_code)));

  // R8
  clear_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr && !refuse_ev) |=> !overrun);

endmodule

bind can_id_filter can_id_filter_chk #(.NUM_BANKS(NUM_BANKS), .HIT_W(HIT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_valid (frame_valid),
  .clr_full    (clr_full),
  .clr_ovr     (clr_ovr),
  .rx_full     (rx_full),
  .overrun     (overrun),
  .hit_code    (hit_code),
  .match_vec   (match_vec),
  .any_match   (any_match),
  .accept_ev   (accept_ev),
  .refuse_ev   (refuse_ev)
);

// File: tb/sim_can_id_filter.sv
module sim_can_id_filter;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 100000;

  typedef struct packed {
    logic [31:0] id;
    logic        acc;
    logic [2:0]  hit;
  } vec_t;

  // Bank 0: 0x123456xx ; bank 1: 0x1234xxxx
  localparam vec_t VECS [9] = '{
    '{32'h12345678, 1'b1, 3'd0},   // R4 both match
    '{32'h123456AB, 1'b1, 3'd0},   // R2 masked low byte
    '{32'h1234ABCD, 1'b1, 3'd1},   // R3 bank 1 only
    '{32'h12355678, 1'b0, 3'd1},   // R5 neither
    '{32'h12340001, 1'b1, 3'd1},   // R9 RTR masked in bank 1
    '{32'h12345700, 1'b1, 3'd1},   // R3 byte 2 differs for bank 0
    '{32'h92345678, 1'b0, 3'd1},   // R5 ID28 differs
    '{32'h12245678, 1'b0, 3'd1},   // R9 SRR differs
    '{32'h123C5678, 1'b0, 3'd1}    // R9 IDE differs
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_valid = 1'b0;
  logic [31:0] frame_id = '0;
  logic [63:0] acc_pattern = '0;
  logic [63:0] acc_mask = '0;
  logic        clr_full = 1'b0;
  logic        clr_ovr = 1'b0;
  logic        rx_full;
  logic        overrun;
  logic [2:0]  hit_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_id_filter u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame_id    (frame_id),
    .acc_pattern (acc_pattern),
    .acc_mask    (acc_mask),
    .clr_full    (clr_full),
    .clr_ovr     (clr_ovr),
    .rx_full     (rx_full),
    .overrun     (overrun),
    .hit_code    (hit_code)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Strobe one frame, optionally with clear pulses in the same cycle.
  task automatic send(input logic [31:0] id, input bit cf, input bit co);
    @(negedge clk);
    frame_valid = 1'b1; frame_id = id; clr_full = cf; clr_ovr = co;
    @(negedge clk);
    frame_valid = 1'b0; clr_full = 1'b0; clr_ovr = 1'b0;
  endtask

  task automatic pulse(input bit cf, input bit co);
    @(negedge clk);
    clr_full = cf; clr_ovr = co;
    @(negedge clk);
    clr_full = 1'b0; clr_ovr = 1'b0;
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", MAX_CYCLES, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] last_hit;
    acc_pattern = {32'h12345600, 32'h12345678};
    acc_mask    = {32'h0000FFFF, 32'h000000FF};
    repeat (3) @(negedge clk);
    check(rx_full == 1'b0, "R1 full", rx_full, 0);
    check(overrun == 1'b0, "R1 ovr", overrun, 0);
    check(hit_code == 3'd0, "R1 hit", hit_code, 0);
    rst_n = 1'b1;
    @(negedge clk);

    last_hit = 3'd0;
    for (int i = 0; i < 9; i++) begin
      pulse(1'b1, 1'b0);
      send(VECS[i].id, 1'b0, 1'b0);
      if (VECS[i].acc) last_hit = VECS[i].hit;
      check(rx_full == VECS[i].acc, "R2/R5/R9 full", rx_full, VECS[i].acc);
      check(hit_code == last_hit, "R3/R4 hit", hit_code, last_hit);
      check(overrun == 1'b0, "R5 ovr", overrun, 0);
    end

    // R6: fill, then send a bank-1 frame while full
    pulse(1'b1, 1'b0);
    send(32'h12345678, 1'b0, 1'b0);
    send(32'h1234ABCD, 1'b0, 1'b0);
    check(overrun == 1'b1, "R6 ovr", overrun, 1);
    check(hit_code == 3'd0, "R6 hit", hit_code, 0);
    check(rx_full == 1'b1, "R6 full", rx_full, 1);

    // R5: non-matching frame while full does not overrun further state
    pulse(1'b0, 1'b1);
    check(overrun == 1'b0, "R8 ovr clear", overrun, 0);
    send(32'hFFFFFFFF, 1'b0, 1'b0);
    check(overrun == 1'b0, "R5 no ovr on reject", overrun, 0);

    // R7
    pulse(1'b1, 1'b0);
    check(rx_full == 1'b0, "R7 full clear", rx_full, 0);
    check(hit_code == 3'd0, "R7 hit holds", hit_code, 0);

    // R11: set full, then clear and bank-1 frame together
    send(32'h12345678, 1'b0, 1'b0);
    send(32'h1234ABCD, 1'b1, 1'b0);
    check(rx_full == 1'b1, "R11 full", rx_full, 1);
    check(hit_code == 3'd1, "R11 hit", hit_code, 1);
    check(overrun == 1'b0, "R11 ovr", overrun, 0);

    // R10: standard ID 0x5A3, RTR=0 IDE=0 in bank 1
    acc_pattern = {32'hB4600000, 32'h00000000};
    acc_mask    = {32'h0007FFFF, 32'h00000000};
    pulse(1'b1, 1'b0);
    send(32'hB4601234, 1'b0, 1'b0);
    check(rx_full == 1'b1, "R10 std accept", rx_full, 1);
    check(hit_code == 3'd1, "R10 std hit", hit_code, 1);
    pulse(1'b1, 1'b0);
    send(32'hB4680000, 1'b0, 1'b0);
    check(rx_full == 1'b0, "R10 std IDE reject", rx_full, 0);
    send(32'hB4700000, 1'b0, 1'b0);
    check(rx_full == 1'b0, "R10 std RTR reject", rx_full, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule